// File: doc/BRIEF.md
# Pulse Counter with Framed Serial Readout

This block is a small up-counter that counts input pulses and makes its value available only through a serial line. While the count enable is high, every new pulse on the count input moves the count up by one. The count wraps from all ones back to zero. The counter is a chain of toggle stages: the lowest stage toggles on every pulse, and each higher stage toggles when all stages below it are at one.

A separate shift strobe reads the count out. The first strobe while the line is idle takes a snapshot of the count and drives a start bit. Each later strobe puts the next count bit on the line, most significant bit first, and then a stop bit. The snapshot is taken at that first strobe, so pulses that arrive during the readout still update the live count and leave the bits already captured for the frame unchanged.

Both the count input and the shift input are level signals sampled in the system clock. Only a rising edge seen at a clock edge has an effect. An asynchronous reset clears the count and abandons any frame in progress.

Top module: `tally_frame_tx`

## Requirements
- R1: While `rst_n` is low, and without waiting for a clock edge, the count is cleared to zero, `ser_out` is 1 and `busy` is 0, even in the middle of a frame. The next frame after reset reads a count of 0.
- R2: With `cnt_en` high, each rising edge of `cnt_pulse` seen at a clock edge adds one to the count. A pulse held high for several cycles counts once.
- R3: With `cnt_en` low, rising edges on `cnt_pulse` leave the count unchanged.
- R4: The count wraps from 2^CNT_W-1 (7 by default) to 0 on the next counted pulse.
- R5: When no frame is in progress, `ser_out` rests at 1 (idle level) and `busy` is 0.
- R6: The first rising edge of `shift_strobe` while idle captures the count, drives the start bit 0 on `ser_out` and raises `busy`. Both change at that clock edge.
- R7: The next CNT_W strobe edges put the captured count bits on `ser_out`, most significant bit first. The strobe edge after those drives the stop bit 1 and drops `busy` at the same edge, so a frame is CNT_W+2 strobes long.
- R8: Pulses counted while a frame is in progress do not change the bits already captured for it, and the next frame carries the updated count. A count pulse and a capturing shift strobe at the same clock edge capture the count from before that pulse.
- R9: Between shift strobe edges during a frame, `ser_out` and `busy` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count enable; gates pulses on `cnt_pulse` |
| cnt_pulse | input | 1 | Count pulse level; a rising edge is one event |
| shift_strobe | input | 1 | Shift strobe level; a rising edge is one shift step |
| ser_out | output | 1 | Serial line: start 0, count bits MSB first, stop 1, idle 1 |
| busy | output | 1 | High from capture until the stop bit is driven |

## Verification
The bench reads every count value it produces back through a complete frame. A wrong bit order or a missing start or stop bit therefore shows up as a mismatched frame. It holds `cnt_pulse` high for several cycles: a design that counts levels instead of edges would add too much. It pulses while `cnt_en` is low: a design that ignores the enable would move the count. It runs the count past its top value: a design that saturates instead of wrapping would stick at seven. It counts during a frame and also at the same edge as a capturing strobe: a design without a snapshot, or one that captures after the increment, would send the wrong bits. It drops reset in the middle of a frame and samples before any clock edge: a design with a synchronous reset, or one that does not clear the shifter, would leave `busy` high or the line low.

// File: rtl/tally_pkg.sv
package tally_pkg;
   // Line levels of the serial frame
   localparam logic START_LVL = 1'b0;
   localparam logic STOP_LVL  = 1'b1;
   localparam logic IDLE_LVL  = 1'b1;
   // Framing bits added around the count bits
   localparam int unsigned FRAME_EXTRA = 2;
endpackage

// File: rtl/strobe_rise.sv
module strobe_rise (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic rise
);
   logic lvl_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_d <= 1'b0;
      else        lvl_d <= lvl;
   end

   assign rise = lvl & ~lvl_d;
endmodule

// File: rtl/tflop_counter.sv
module tflop_counter #(
   parameter int unsigned W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   output logic [W-1:0] q
);
   // Toggle enable chain: stage i toggles when step and all lower stages are 1
   logic [W:0] tgl;
   assign tgl[0] = step;

   for (genvar i = 0; i < W; i++) begin : g_stage
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      bit_q <= 1'b0;
         else if (tgl[i]) bit_q <= ~bit_q;
      end
      assign q[i]       = bit_q;
      assign tgl[i + 1] = tgl[i] & bit_q;
   end
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
   import tally_pkg::*;
#(
   parameter int unsigned W         = 3,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv,
   input  logic [W-1:0] snap,
   output logic         ser,
   output logic         busy
);
   localparam int unsigned SR_W = W + 1;
   localparam int unsigned CW   = $clog2(W + FRAME_EXTRA);

   logic [W-1:0]    ordered;
   logic [SR_W-1:0] sreg;
   logic [CW-1:0]   left;
   logic            ser_q;

   // Bit 0 of ordered is sent first
   if (MSB_FIRST) begin : g_msb
      for (genvar i = 0; i < W; i++) begin : g_rev
         assign ordered[i] = snap[W-1-i];
      end
   end else begin : g_lsb
      assign ordered = snap;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg  <= '1;
         ser_q <= IDLE_LVL;
         left  <= '0;
      end else if (adv) begin
         if (left == '0) begin
            sreg  <= {STOP_LVL, ordered};
            ser_q <= START_LVL;
            left  <= CW'(SR_W);
         end else begin
            ser_q <= sreg[0];
            sreg  <= {STOP_LVL, sreg[SR_W-1:1]};
            left  <= left - 1'b1;
         end
      end
   end

   assign ser  = ser_q;
   assign busy = (left != '0);
endmodule

// File: rtl/tally_frame_tx.sv
module tally_frame_tx #(
   parameter int unsigned CNT_W     = 3,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cnt_en,
   input  logic cnt_pulse,
   input  logic shift_strobe,
   output logic ser_out,
   output logic busy
);
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_width
      $error("tally_frame_tx: CNT_W must be 1..32");
   end

   logic             pulse_rise;
   logic             shift_rise;
   logic [CNT_W-1:0] count_q;

   strobe_rise u_pulse_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (cnt_pulse),
      .rise  (pulse_rise)
   );

   strobe_rise u_shift_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (shift_strobe),
      .rise  (shift_rise)
   );

   tflop_counter #(.W(CNT_W)) u_count (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (pulse_rise & cnt_en),
      .q     (count_q)
   );

   frame_shifter #(.W(CNT_W), .MSB_FIRST(MSB_FIRST)) u_frame (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (shift_rise),
      .snap  (count_q),
      .ser   (ser_out),
      .busy  (busy)
   );
endmodule

// File: rtl/tally_frame_chk.sv
module tally_frame_chk #(
   parameter int unsigned CNT_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cnt_en,
   input logic             cnt_pulse,
   input logic             shift_strobe,
   input logic             ser_out,
   input logic             busy,
   input logic [CNT_W-1:0] count_q
);
   logic p_d, s_d;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_d <= 1'b0;
         s_d <= 1'b0;
      end else begin
         p_d <= cnt_pulse;
         s_d <= shift_strobe;
      end
   end
   logic p_edge, s_edge;
   assign p_edge = cnt_pulse & ~p_d;
   assign s_edge = shift_strobe & ~s_d;

   // R2 R4
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (p_edge && cnt_en) |=> count_q == CNT_W'($past(count_q) + 1'b1));

   // R3
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(p_edge && cnt_en) |=> $stable(count_q));

   // R5
   idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> ser_out);

   // R6
   frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_edge && !busy) |=> (busy && !ser_out));

   // R9
   frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !s_edge) |=> (busy && $stable(ser_out)));
endmodule

bind tally_frame_tx tally_frame_chk #(.CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cnt_en       (cnt_en),
   .cnt_pulse    (cnt_pulse),
   .shift_strobe (shift_strobe),
   .ser_out      (ser_out),
   .busy         (busy),
   .count_q      (count_q)
);

// File: tb/sim_tally_frame_tx.sv
`timescale 1ns/1ps
module sim_tally_frame_tx;
   localparam int W   = 3;
   localparam int MOD = 1 << W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cnt_en = 1'b1;
   logic cnt_pulse = 1'b0;
   logic shift_strobe = 1'b0;
   logic ser_out, busy;

   int errors = 0;
   int checks = 0;
   int exp_cnt = 0;

   always #10 clk = ~clk;

   tally_frame_tx #(.CNT_W(W), .MSB_FIRST(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_pulse(cnt_pulse),
      .shift_strobe(shift_strobe), .ser_out(ser_out), .busy(busy)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic pulse(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) cnt_pulse = 1'b1;
         @(negedge clk) cnt_pulse = 1'b0;
         if (cnt_en) exp_cnt = (exp_cnt + 1) % MOD;
      end
   endtask

   task automatic shift_step();
      @(negedge clk) shift_strobe = 1'b1;
      @(negedge clk) shift_strobe = 1'b0;
      #1;
   endtask

   // Data bits and stop bit of a frame whose start bit is already on the line
   task automatic finish_frame(input int v, input string req);
      for (int i = W - 1; i >= 0; i--) begin
         shift_step();
         chk({req, " R7 data bit"}, ser_out, (v >> i) & 1);
         chk({req, " R7 busy in data"}, busy, 1);
      end
      shift_step();
      chk({req, " R7 stop bit"}, ser_out, 1);
      chk({req, " R7 busy after stop"}, busy, 0);
   endtask

   task automatic read_frame(input int v, input string req);
      shift_step();
      chk({req, " R6 start bit"}, ser_out, 0);
      chk({req, " R6 busy at start"}, busy, 1);
      finish_frame(v, req);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      #5;
      chk("R1 R5 idle line in reset", ser_out, 1);
      chk("R1 R5 busy in reset", busy, 0);
      @(negedge clk) rst_n = 1'b1;
      repeat (2) @(negedge clk);
      #1;
      chk("R5 idle line after reset", ser_out, 1);
      chk("R5 busy idle", busy, 0);
      read_frame(0, "reset value R1");
   endtask

   task automatic t_count();
      pulse(5);
      read_frame(exp_cnt, "five pulses R2");
   endtask

   task automatic t_gate();
      cnt_en = 1'b0;
      pulse(4);
      cnt_en = 1'b1;
      read_frame(exp_cnt, "disabled pulses R3");
   endtask

   task automatic t_wrap();
      pulse(3);
      chk("R4 model wrap", exp_cnt, 0);
      read_frame(exp_cnt, "wrap to zero R4");
      pulse(MOD - 1);
      read_frame(exp_cnt, "top value R4");
   endtask

   task automatic t_hold();
      @(negedge clk) cnt_pulse = 1'b1;
      repeat (5) @(negedge clk);
      cnt_pulse = 1'b0;
      exp_cnt = (exp_cnt + 1) % MOD;
      read_frame(exp_cnt, "held pulse counts once R2");
   endtask

   task automatic t_during();
      int snap_v;
      snap_v = exp_cnt;
      shift_step();
      chk("R6 start before mid-frame pulses", ser_out, 0);
      pulse(2);
      repeat (3) @(negedge clk);
      #1;
      chk("R9 line held between strobes", ser_out, 0);
      chk("R9 busy held between strobes", busy, 1);
      finish_frame(snap_v, "snapshot R8");
      read_frame(exp_cnt, "next frame after mid-frame count R8");
   endtask

   task automatic t_same_edge();
      int snap_v;
      snap_v = exp_cnt;
      @(negedge clk) begin cnt_pulse = 1'b1; shift_strobe = 1'b1; end
      @(negedge clk) begin cnt_pulse = 1'b0; shift_strobe = 1'b0; end
      #1;
      exp_cnt = (exp_cnt + 1) % MOD;
      chk("R8 start on shared edge", ser_out, 0);
      finish_frame(snap_v, "pre-increment capture R8");
      read_frame(exp_cnt, "count after shared edge R8");
   endtask

   task automatic t_async();
      pulse(1);
      shift_step();
      shift_step();
      chk("R1 frame in progress before reset", busy, 1);
      @(negedge clk);
      #5 rst_n = 1'b0;
      #1;
      chk("R1 async line idle", ser_out, 1);
      chk("R1 async busy cleared", busy, 0);
      @(negedge clk) rst_n = 1'b1;
      exp_cnt = 0;
      repeat (2) @(negedge clk);
      read_frame(0, "count cleared R1");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_count();
      t_gate();
      t_wrap();
      t_hold();
      t_during();
      t_same_edge();
      t_async();
      repeat (3) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(20 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule